// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Port

This block is the clocked shift-register mode of a serial port. A single data line carries bytes in either direction, and the port drives a separate shift clock. The direction is chosen by a receive-enable input. When receive-enable is low, a write to the transmit buffer shifts one byte out. When it is high, the port shifts one byte in. A reception starts either on a rising edge of the data input or when software strobes the receive-flag clear.

The shift clock comes from a fixed division of the system clock, set by `DIV`. It idles high. Each bit is held for one full shift-clock period: the clock is low for the first half and high for the second. Incoming data is captured at the rising shift-clock edge. Each direction has a sticky completion flag and a one-cycle interrupt pulse, which fires when the flag goes from clear to set. Dropping receive-enable cancels a reception that is in progress. A cancelled reception sets no flag and leaves the receive buffer unchanged.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, `sclk_o` and `data_o` are 1, and `data_oe_o`, `rx_data_o`, both flags and both interrupt pulses are 0.
- R2: A `tx_wr_i` strobe starts a transmission only while `rx_en_i` is 0 and the port is idle. A strobe while `rx_en_i` is 1 leaves `data_oe_o` at 0 and `sclk_o` at 1. A strobe during a transfer does not change the bits being shifted.
- R3: In cycle i after the accepting clock edge (i = 0 .. 8*DIV-1), `data_oe_o` is 1 and `data_o` carries bit i/DIV of the written byte, bit 0 first. `sclk_o` is 0 when i mod DIV < DIV/2 and 1 otherwise.
- R4: In cycle 8*DIV after the accepting edge, `tx_done_o` is 1, `tx_int_o` is 1 for that one cycle only, `data_oe_o` is 0 and `sclk_o` is 1.
- R5: While `rx_en_i` is 1 and the port is idle, a 0-to-1 change on `data_i` starts a reception.
- R6: While `rx_en_i` is 1 and the port is idle, an `rx_flag_clr_i` strobe starts a reception, and the same edge clears `rx_done_o`.
- R7: During a reception, bit k is taken from `data_i` at the clock edge where `sclk_o` rises in period k, bit 0 first. In cycle 8*DIV after the start edge, `rx_data_o` holds the byte, `rx_done_o` is 1 and `rx_int_o` pulses for one cycle.
- R8: Dropping `rx_en_i` during a reception returns `sclk_o` to 1 in the next cycle. No flag is set, and `rx_data_o` keeps its earlier value.
- R9: While `rx_en_i` is 0, no edge on `data_i` starts a reception: `sclk_o` stays 1.
- R10: Each completion flag stays set until its clear strobe. If a completion and a clear fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive enable; low selects transmit |
| tx_wr_i | input | 1 | Transmit buffer write strobe |
| tx_data_i | input | DATA_W | Byte to transmit |
| rx_flag_clr_i | input | 1 | Clear receive flag (also starts a reception when enabled) |
| tx_flag_clr_i | input | 1 | Clear transmit flag |
| data_i | input | 1 | Data line input |
| data_o | output | 1 | Data line output |
| data_oe_o | output | 1 | Data line output enable |
| sclk_o | output | 1 | Shift clock, idles high |
| rx_data_o | output | DATA_W | Receive buffer |
| rx_done_o | output | 1 | Receive complete flag |
| tx_done_o | output | 1 | Transmit complete flag |
| rx_int_o | output | 1 | Receive interrupt pulse |
| tx_int_o | output | 1 | Transmit interrupt pulse |

## Verification
The assertions assume that `data_i` and the strobes are synchronous to `clk_i`, since the port has no input synchronizer. They also assume that the clear strobes are single-cycle pulses. The bench drives every input at the falling system-clock edge, so each change is seen cleanly at the next rising edge. Received bits are placed on `data_i` at the start of each shift period, well before the capture edge. Before an edge-started reception, the bench clears the receive flag with receive disabled, so the clear cannot start a stray transfer.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } ssp_state_e;
endpackage

// File: rtl/ssp_bit_timer.sv
module ssp_bit_timer #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sample_o,
  output logic bit_end_o,
  output logic sclk_o
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF  = DIV / 2;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] CNT_SMP  = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // capture on the edge where the shift clock turns high
  assign sample_o  = run_i && (cnt_q == CNT_SMP);
  assign bit_end_o = run_i && (cnt_q == CNT_LAST);
  assign sclk_o    = !run_i || (cnt_q >= CNT_HALF);
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] sh_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_data_i;
    else if (shift_i) sh_q <= {fill_i, sh_q[DATA_W-1:1]};
  end

  assign sh_o = sh_q;
endmodule

// File: rtl/ssp_flag.sv
module ssp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      // set wins over clear
      flag_q <= set_i | (flag_q & ~clr_i);
      irq_q  <= set_i & ~flag_q;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_flag_clr_i,
  input  logic              tx_flag_clr_i,
  input  logic              data_i,
  output logic              data_o,
  output logic              data_oe_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_done_o,
  output logic              tx_done_o,
  output logic              rx_int_o,
  output logic              tx_int_o
);
  localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  ssp_state_e        state_q, state_d;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh, rx_data_q;
  logic              data_q, run, sample, bit_end, last_bit;
  logic              rx_go, tx_go, rx_set, tx_set, load, shift, fill;

  assign run      = (state_q != ST_IDLE);
  assign last_bit = (bit_q == BIT_LAST);
  assign rx_go    = rx_en_i && ((data_i && !data_q) || rx_flag_clr_i);
  assign tx_go    = !rx_en_i && tx_wr_i;

  always_comb begin
    state_d = state_q;
    rx_set  = 1'b0;
    tx_set  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tx_go)      state_d = ST_TX;
        else if (rx_go) state_d = ST_RX;
      end
      ST_TX: begin
        if (bit_end && last_bit) begin
          state_d = ST_IDLE;
          tx_set  = 1'b1;
        end
      end
      ST_RX: begin
        if (!rx_en_i) state_d = ST_IDLE;  // abort
        else if (bit_end && last_bit) begin
          state_d = ST_IDLE;
          rx_set  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      data_q    <= 1'b1;
      rx_data_q <= '0;
    end else begin
      state_q <= state_d;
      data_q  <= data_i;
      if (!run)         bit_q <= '0;
      else if (bit_end) bit_q <= bit_q + 1'b1;
      if (rx_set)       rx_data_q <= sh;
    end
  end

  assign load  = (state_q == ST_IDLE) && tx_go;
  assign shift = ((state_q == ST_TX) && bit_end) || ((state_q == ST_RX) && sample);
  assign fill  = (state_q == ST_RX) ? data_i : 1'b1;

  ssp_bit_timer #(.DIV(DIV)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .sample_o  (sample),
    .bit_end_o (bit_end),
    .sclk_o    (sclk_o)
  );

  ssp_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (tx_data_i),
    .shift_i     (shift),
    .fill_i      (fill),
    .sh_o        (sh)
  );

  ssp_flag i_rx_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rx_set),
    .clr_i  (rx_flag_clr_i),
    .flag_o (rx_done_o),
    .irq_o  (rx_int_o)
  );

  ssp_flag i_tx_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tx_set),
    .clr_i  (tx_flag_clr_i),
    .flag_o (tx_done_o),
    .irq_o  (tx_int_o)
  );

  assign data_o    = (state_q == ST_TX) ? sh[0] : 1'b1;
  assign data_oe_o = (state_q == ST_TX);
  assign rx_data_o = rx_data_q;
endmodule

// File: rtl/sync_shift_port_chk.sv
module sync_shift_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_en_i,
  input logic tx_wr_i,
  input logic rx_flag_clr_i,
  input logic tx_flag_clr_i,
  input logic data_oe_o,
  input logic sclk_o,
  input logic rx_done_o,
  input logic tx_done_o,
  input logic rx_int_o,
  input logic tx_int_o
);
  assert_no_tx_rx_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_oe_o && rx_en_i && tx_wr_i) |=> !data_oe_o);

  assert_tx_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> ($past(tx_wr_i) && !$past(rx_en_i)));

  assert_tx_int_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_int_o |-> tx_done_o);

  assert_rx_int_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_int_o |-> rx_done_o);

  assert_rx_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !data_oe_o && !tx_wr_i) |=> sclk_o);

  assert_tx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o && !tx_flag_clr_i) |=> tx_done_o);

  assert_rx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !rx_flag_clr_i) |=> rx_done_o);
endmodule

bind sync_shift_port sync_shift_port_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_en_i       (rx_en_i),
  .tx_wr_i       (tx_wr_i),
  .rx_flag_clr_i (rx_flag_clr_i),
  .tx_flag_clr_i (tx_flag_clr_i),
  .data_oe_o     (data_oe_o),
  .sclk_o        (sclk_o),
  .rx_done_o     (rx_done_o),
  .tx_done_o     (tx_done_o),
  .rx_int_o      (rx_int_o),
  .tx_int_o      (tx_int_o)
);

// File: tb/test_sync_shift_port.sv
`timescale 1ns/1ps
module test_sync_shift_port;
  localparam int DW   = 8;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int NCYC = 8 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b0, tx_wr = 1'b0, rx_clr = 1'b0, tx_clr = 1'b0, din = 1'b1;
  logic [DW-1:0] tx_data = '0;
  logic dout, oe, sclk, rx_done, tx_done, rx_int, tx_int;
  logic [DW-1:0] rx_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sync_shift_port #(.DATA_W(DW), .DIV(DIV)) i_sync_shift_port (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .tx_wr_i(tx_wr),
    .tx_data_i(tx_data), .rx_flag_clr_i(rx_clr), .tx_flag_clr_i(tx_clr),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .sclk_o(sclk),
    .rx_data_o(rx_data), .rx_done_o(rx_done), .tx_done_o(tx_done),
    .rx_int_o(rx_int), .tx_int_o(tx_int)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_tx();
    @(negedge clk); tx_clr = 1'b1;
    @(negedge clk); tx_clr = 1'b0;
  endtask

  // transmit one byte; optionally poke a second write mid-transfer
  task automatic tx_byte(input logic [DW-1:0] b, input bit poke);
    int err_w = 0;
    @(negedge clk); tx_wr = 1'b1; tx_data = b;
    @(negedge clk); tx_wr = 1'b0;
    for (int i = 0; i < NCYC; i++) begin
      if (poke && i == 5) begin tx_wr = 1'b1; tx_data = ~b; end
      if (poke && i == 6) tx_wr = 1'b0;
      if (sclk !== ((i % DIV) >= HALF) || oe !== 1'b1 || dout !== b[i/DIV] || tx_done !== 1'b0)
        err_w++;
      @(negedge clk);
    end
    chk(err_w == 0, poke ? "R2/R3 busy write" : "R3 waveform", err_w, 0);
    chk(tx_done && tx_int && !oe && sclk, "R4 done", {tx_done, tx_int, oe, sclk}, 4'b1101);
    @(negedge clk);
    chk(tx_done && !tx_int, "R10 hold", {tx_done, tx_int}, 2'b10);
    clr_tx();
    chk(!tx_done, "R10 clear", tx_done, 0);
  endtask

  // receive one byte, started by data edge or by flag clear
  task automatic rx_byte(input logic [DW-1:0] b, input bit by_edge);
    int err_w = 0;
    if (by_edge) begin
      @(negedge clk); rx_en = 1'b0; rx_clr = 1'b1;
      @(negedge clk); rx_clr = 1'b0; rx_en = 1'b1; din = 1'b0;
      @(negedge clk); din = 1'b1;
    end else begin
      @(negedge clk); rx_clr = 1'b1;
    end
    @(negedge clk); rx_clr = 1'b0;
    chk(!rx_done && !sclk, by_edge ? "R5 start" : "R6 start", {rx_done, sclk}, 0);
    for (int i = 0; i < NCYC; i++) begin
      if ((i % DIV) == 0) din = b[i/DIV];
      if (sclk !== ((i % DIV) >= HALF) || oe !== 1'b0 || rx_done !== 1'b0) err_w++;
      @(negedge clk);
    end
    chk(err_w == 0, "R7 clocking", err_w, 0);
    chk(rx_data == b && rx_done && rx_int && sclk, "R7 data",
        {rx_data, rx_done, rx_int, sclk}, {b, 3'b111});
    @(negedge clk);
    chk(rx_done && !rx_int, "R10 rx hold", {rx_done, rx_int}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk && dout && !oe && rx_data == 0 && !rx_done && !tx_done && !rx_int && !tx_int,
        "R1 reset", {sclk, dout, oe, rx_data, rx_done, tx_done, rx_int, tx_int},
        {2'b11, 1'b0, 8'h00, 4'b0000});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 256; v++) tx_byte(DW'(v), (v % 7) == 3);

    // R2: write ignored while receive is enabled
    begin
      int err_w = 0;
      @(negedge clk); rx_en = 1'b1; tx_wr = 1'b1; tx_data = 8'h5A;
      @(negedge clk); tx_wr = 1'b0;
      for (int i = 0; i < NCYC; i++) begin
        if (oe || !sclk || tx_done) err_w++;
        @(negedge clk);
      end
      chk(err_w == 0, "R2 ignored", err_w, 0);
    end

    for (int v = 0; v < 256; v++) rx_byte(DW'(v ^ 8'h3C), v[0]);

    // R8: abort partway through
    begin
      int err_w = 0;
      logic [DW-1:0] keep;
      keep = rx_data;
      @(negedge clk); rx_en = 1'b0; rx_clr = 1'b1;
      @(negedge clk); rx_clr = 1'b0; rx_en = 1'b1;
      @(negedge clk); rx_clr = 1'b1;
      @(negedge clk); rx_clr = 1'b0;
      for (int i = 0; i < 3 * DIV + 1; i++) begin
        if ((i % DIV) == 0) din = ~din;
        @(negedge clk);
      end
      rx_en = 1'b0;
      @(negedge clk);
      chk(sclk, "R8 sclk", sclk, 1);
      for (int i = 0; i < 2 * NCYC; i++) begin
        if (!sclk || rx_done || rx_int) err_w++;
        @(negedge clk);
      end
      chk(err_w == 0 && rx_data == keep, "R8 no result", {err_w[7:0], rx_data}, {8'h00, keep});
    end

    // R9: data edges with receive disabled
    begin
      int err_w = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); din = ~din;
        repeat (DIV) begin
          @(negedge clk);
          if (!sclk) err_w++;
        end
      end
      chk(err_w == 0, "R9 disabled", err_w, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule